// File: doc/BRIEF.md
# Synchronizable Clock Divider with Slip

This block divides a fast input clock by 1, 2, 4, 8, 16 or 32, picked by a 3-bit ratio code. A run control (sync) holds the divider cleared while it is low. When it goes high, the first output edge appears after a fixed latency that depends on the ratio. Several dividers fed from one sync source therefore launch in lockstep.

A slip request swallows exactly one input cycle, which moves the output phase back by one input period. A launch-phase bit picks whether the output changes on the rising input edge (late) or half a period earlier on the falling edge (early). Combining a slip with a late-to-early switch gives a net step of half an input period.

Sync and slip each come from a register-style level input, or, when enabled, from one shared external trigger pin. That pin passes through a two-flop synchroniser. Status outputs show that the divider is held, that a slip is being applied, and that the divider is released but has not yet launched its first edge.

Top module: `clk_div_sync`

## Requirements
- R1: Ratio code c (0..5) gives an output period of 2^c input periods; code 0 passes the input clock through.
- R2: Codes 6 and 7 hold the divider cleared and keep `div_clk` low.
- R3: While the effective sync level is 0, `div_clk` stays low and `sync_hold` is 1.
- R4: With `launch_late`=1, the first rising output edge comes x input periods after the rising clock edge that samples sync=1. x is 1 for code 0 and N/2+1 for ratio N>1.
- R5: With `launch_late`=0 and N>1, the first rising output edge comes N/2+0.5 input periods after that edge, which is half a period earlier than in R4.
- R6: A 0-to-1 transition of the slip source freezes the divider for exactly one input period, so every later output edge moves by one input period; code 0 loses one output pulse. `slip_busy` is 1 during that frozen period only. The source must go low again before another slip can be taken.
- R7: One slip followed by switching `launch_late` from 1 to 0 moves the output by half an input period in net.
- R8: With `pin_sync_en`=1 and `pin_slip_en`=0, the trigger pin is the sync level after two synchroniser flops, so its release latency is R4 plus 2 periods.
- R9: With `pin_slip_en`=1 and `pin_sync_en`=0, a rising edge on the trigger pin (held high for more than 4 input cycles) performs the slip of R6.
- R10: With both pin enables set, `cfg_err` is 1, the pin has no effect, and `reg_sync`/`reg_slip` stay in control.
- R11: `first_wait` is 1 from the cycle after sync is sampled high until the first output launch, and 0 afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast input clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ratio_sel | input | 3 | Ratio code: 0 bypass, c gives divide by 2^c, 6/7 unused |
| launch_late | input | 1 | 1 = rising-edge launch, 0 = falling-edge launch |
| reg_sync | input | 1 | Sync run level from registers |
| reg_slip | input | 1 | Slip request from registers, acts on its rising edge |
| trig_pin | input | 1 | Asynchronous external trigger |
| pin_sync_en | input | 1 | Trigger pin drives sync |
| pin_slip_en | input | 1 | Trigger pin drives slip |
| div_clk | output | 1 | Divided clock |
| slip_busy | output | 1 | Slip freeze in progress |
| sync_hold | output | 1 | Divider held by sync |
| first_wait | output | 1 | Released, first edge not yet launched |
| cfg_err | output | 1 | Both pin enables set |

## Verification
Two functions can act in the same cycle: a slip freeze and a launch-phase change, which both move the output phase. A single pin edge can also be claimed by both sync and slip. The bench issues a slip and then flips the phase from late to early, and it judges the result by the distance of a later output edge from a reference edge, taken modulo the output period in half-period units. The conflicting-enable case pulses the pin while register sync keeps the divider running, and it expects zero phase shift with `cfg_err` raised.

// File: rtl/clkdiv_pkg.sv
package clkdiv_pkg;
  localparam int MAX_LOG = 5;
  localparam int CNT_W   = MAX_LOG;
  localparam int CODE_W  = 3;

  function automatic logic code_ok(input logic [CODE_W-1:0] code);
    return code <= CODE_W'(MAX_LOG);
  endfunction

  // terminal count of the half-period counter: N/2 - 1
  function automatic logic [CNT_W-1:0] half_term(input logic [CODE_W-1:0] code);
    logic [CNT_W-1:0] half;
    if (code == '0) half = CNT_W'(1);
    else            half = CNT_W'(1) << (code - CODE_W'(1));
    return half - CNT_W'(1);
  endfunction
endpackage

// File: rtl/clkdiv_trig.sv
module clkdiv_trig #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic trig_pin,
  input  logic pin_sync_en,
  input  logic pin_slip_en,
  input  logic reg_sync,
  input  logic reg_slip,
  output logic run_q,
  output logic slip_go,
  output logic conflict
);
  logic [SYNC_STAGES-1:0] chain;
  logic pin_s, use_pin_sync, use_pin_slip, run_src, slip_src, slip_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= '0;
    else        chain <= {chain[SYNC_STAGES-2:0], trig_pin};
  end
  assign pin_s = chain[SYNC_STAGES-1];

  assign conflict     = pin_sync_en & pin_slip_en;
  assign use_pin_sync = pin_sync_en & ~pin_slip_en;
  assign use_pin_slip = pin_slip_en & ~pin_sync_en;
  assign run_src      = use_pin_sync ? pin_s : reg_sync;
  assign slip_src     = use_pin_slip ? pin_s : reg_slip;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q   <= 1'b0;
      slip_d  <= 1'b0;
      slip_go <= 1'b0;
    end else begin
      run_q   <= run_src;
      slip_d  <= slip_src;
      slip_go <= slip_src & ~slip_d;
    end
  end

  AST_SLIP_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    slip_go |=> !slip_go); // R6
  AST_CONFLICT_REG_SYNC: assert property (@(posedge clk) disable iff (!rst_n)
    conflict |=> run_q == $past(reg_sync)); // R10
endmodule

// File: rtl/clkdiv_core.sv
module clkdiv_core
  import clkdiv_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic              hold,
  input  logic [CODE_W-1:0] ratio_sel,
  output logic              bypass,
  output logic              q_rise,
  output logic              q_fall,
  output logic              gate
);
  logic [CNT_W-1:0] cnt, term;
  logic tog, ok, active;

  assign ok     = code_ok(ratio_sel);
  assign bypass = (ratio_sel == '0);
  assign active = run & ok;
  assign term   = half_term(ratio_sel);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
      tog <= 1'b0;
    end else if (!active || bypass) begin
      cnt <= '0;
      tog <= 1'b0;
    end else if (!hold) begin
      if (cnt >= term) begin
        cnt <= '0;
        tog <= ~tog;
      end else begin
        cnt <= cnt + CNT_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q_rise <= 1'b0;
    else        q_rise <= tog;
  end

  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_fall <= 1'b0;
      gate   <= 1'b0;
    end else begin
      q_fall <= tog;
      gate   <= active & bypass & ~hold;
    end
  end

  AST_SLIP_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    (active && hold && !bypass) |=> ($stable(cnt) && $stable(tog))); // R6
  AST_IDLE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    !active |=> (cnt == '0 && !tog)); // R3
  AST_BAD_CODE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (!ok ##1 !ok) |=> !q_rise); // R2
endmodule

// File: rtl/clk_div_sync.sv
module clk_div_sync
  import clkdiv_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CODE_W-1:0] ratio_sel,
  input  logic              launch_late,
  input  logic              reg_sync,
  input  logic              reg_slip,
  input  logic              trig_pin,
  input  logic              pin_sync_en,
  input  logic              pin_slip_en,
  output logic              div_clk,
  output logic              slip_busy,
  output logic              sync_hold,
  output logic              first_wait,
  output logic              cfg_err
);
  logic run_q, slip_go, bypass, q_rise, q_fall, gate, seen;

  clkdiv_trig #(.SYNC_STAGES(SYNC_STAGES)) u_trig (
    .clk(clk), .rst_n(rst_n), .trig_pin(trig_pin),
    .pin_sync_en(pin_sync_en), .pin_slip_en(pin_slip_en),
    .reg_sync(reg_sync), .reg_slip(reg_slip),
    .run_q(run_q), .slip_go(slip_go), .conflict(cfg_err)
  );

  clkdiv_core u_core (
    .clk(clk), .rst_n(rst_n), .run(run_q), .hold(slip_go),
    .ratio_sel(ratio_sel), .bypass(bypass),
    .q_rise(q_rise), .q_fall(q_fall), .gate(gate)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      seen <= 1'b0;
    else if (!run_q) seen <= 1'b0;
    else if (q_rise | q_fall | gate) seen <= 1'b1;
  end

  assign div_clk    = bypass ? (clk & gate) : (launch_late ? q_rise : q_fall);
  assign slip_busy  = slip_go;
  assign sync_hold  = ~run_q;
  assign first_wait = run_q & ~seen;

  AST_HOLD_NO_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    (sync_hold ##1 sync_hold) |-> !gate); // R3
endmodule

// File: tb/tb_clk_div_sync.sv
`timescale 1ns/1ps
module tb_clk_div_sync;
  localparam real T = 5.0;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [2:0] ratio_sel = 3'd1;
  logic launch_late = 1'b1, reg_sync = 1'b0, reg_slip = 1'b0;
  logic trig_pin = 1'b0, pin_sync_en = 1'b0, pin_slip_en = 1'b0;
  logic div_clk, slip_busy, sync_hold, first_wait, cfg_err;
  int checks = 0, failures = 0, rise_cnt = 0;

  always #(T/2) clk = ~clk;

  clk_div_sync dut (
    .clk(clk), .rst_n(rst_n), .ratio_sel(ratio_sel), .launch_late(launch_late),
    .reg_sync(reg_sync), .reg_slip(reg_slip), .trig_pin(trig_pin),
    .pin_sync_en(pin_sync_en), .pin_slip_en(pin_slip_en),
    .div_clk(div_clk), .slip_busy(slip_busy), .sync_hold(sync_hold),
    .first_wait(first_wait), .cfg_err(cfg_err)
  );

  always @(posedge div_clk) rise_cnt++;

  task automatic chk(input bit ok, input string req, input real act, input real exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0.3f expected=%0.3f", req, act, exp);
    end
  endtask

  task automatic negs(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic bit near(input real a, input real b);
    return (a - b < 0.01) && (b - a < 0.01);
  endfunction

  // hold, configure, then release by reg_sync; returns time of first output rise
  task automatic start(input int code, input bit late, output real t1, output real ta);
    @(negedge clk);
    reg_sync = 1'b0; ratio_sel = 3'(code); launch_late = late;
    negs(3);
    chk(div_clk == 1'b0 && sync_hold == 1'b1, "R3", real'(div_clk), 0.0);
    reg_sync = 1'b1;
    ta = $realtime + T/2;
    @(posedge div_clk) t1 = $realtime;
  endtask

  function automatic int phase_h(input real r0, input real rk, input int n);
    int h;
    h = $rtoi((rk - r0) / (T/2) + 0.5);
    return h % (2*n);
  endfunction

  initial begin
    #(T * 150000);
    checks++; failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    real t1, t2, ta, r0, rk, expv;
    int n, c0;
    negs(2);
    chk(div_clk == 0 && slip_busy == 0 && sync_hold == 1 && first_wait == 0, "R3 reset", real'(div_clk), 0.0);
    rst_n = 1'b1;
    negs(2);

    // R1 R4 R5: sweep all valid codes and both launch phases
    for (int code = 0; code <= 5; code++) begin
      for (int late = 0; late <= 1; late++) begin
        n = 1 << code;
        start(code, late[0], t1, ta);
        if (code == 0)    expv = T;
        else if (late==1) expv = (n/2 + 1) * T;
        else              expv = (n/2 + 0.5) * T;
        chk(near(t1 - ta, expv), late ? "R4 latency" : "R5 latency", t1 - ta, expv);
        @(posedge div_clk) t2 = $realtime;
        chk(near(t2 - t1, n * T), "R1 period", t2 - t1, n * T);
      end
    end

    // R11 first_wait
    @(negedge clk); reg_sync = 0; ratio_sel = 3'd3; launch_late = 1; negs(3);
    reg_sync = 1; negs(1);
    chk(first_wait == 1'b1, "R11 waiting", real'(first_wait), 1.0);
    @(posedge div_clk); negs(2);
    chk(first_wait == 1'b0, "R11 launched", real'(first_wait), 0.0);

    // R2 unused codes
    for (int code = 6; code <= 7; code++) begin
      @(negedge clk); ratio_sel = 3'(code); negs(2);
      c0 = rise_cnt; negs(80);
      chk(rise_cnt == c0 && div_clk == 0, "R2 unused code", real'(rise_cnt - c0), 0.0);
    end

    // R6 register slip on divided codes, with busy flag timing
    for (int code = 1; code <= 3; code++) begin
      n = 1 << code;
      start(code, 1'b1, r0, ta);
      @(negedge clk); reg_slip = 1; negs(1);
      chk(slip_busy == 1'b1, "R6 busy high", real'(slip_busy), 1.0);
      negs(1);
      chk(slip_busy == 1'b0, "R6 busy low", real'(slip_busy), 0.0);
      negs(4); reg_slip = 0; negs(3*n + 10);
      @(posedge div_clk) rk = $realtime;
      chk(phase_h(r0, rk, n) == 2, "R6 shift", real'(phase_h(r0, rk, n)), 2.0);
    end

    // R6 bypass loses one pulse
    start(0, 1'b1, r0, ta);
    @(negedge clk); c0 = rise_cnt; reg_slip = 1; negs(6); reg_slip = 0; negs(14);
    chk(rise_cnt - c0 == 19, "R6 bypass pulse", real'(rise_cnt - c0), 19.0);

    // R7 half-period step
    start(2, 1'b1, r0, ta);
    @(negedge clk); reg_slip = 1; negs(6); reg_slip = 0; negs(2);
    launch_late = 0; negs(20);
    @(posedge div_clk) rk = $realtime;
    chk(phase_h(r0, rk, 4) == 1, "R7 half step", real'(phase_h(r0, rk, 4)), 1.0);

    // R8 pin sync
    @(negedge clk); reg_sync = 0; ratio_sel = 3'd1; launch_late = 1;
    pin_sync_en = 1; trig_pin = 0; negs(4);
    chk(sync_hold == 1 && div_clk == 0, "R8 held by pin", real'(sync_hold), 1.0);
    trig_pin = 1; ta = $realtime + T/2;
    @(posedge div_clk) t1 = $realtime;
    chk(near(t1 - ta, 4*T), "R8 pin latency", t1 - ta, 4*T);
    @(negedge clk); trig_pin = 0; pin_sync_en = 0; negs(2);

    // R9 pin slip
    start(2, 1'b1, r0, ta);
    @(negedge clk); pin_slip_en = 1; negs(2);
    trig_pin = 1; negs(6); trig_pin = 0; negs(20);
    @(posedge div_clk) rk = $realtime;
    chk(phase_h(r0, rk, 4) == 2, "R9 pin slip", real'(phase_h(r0, rk, 4)), 2.0);

    // R10 both enables: pin ignored, register sync keeps running
    @(negedge clk); pin_sync_en = 1; negs(1);
    chk(cfg_err == 1'b1, "R10 cfg_err", real'(cfg_err), 1.0);
    @(posedge div_clk) r0 = $realtime;
    @(negedge clk); trig_pin = 1; negs(6); trig_pin = 0; negs(20);
    @(posedge div_clk) rk = $realtime;
    chk(phase_h(r0, rk, 4) == 0 && sync_hold == 0, "R10 pin ignored", real'(phase_h(r0, rk, 4)), 0.0);
    @(negedge clk); pin_sync_en = 0; pin_slip_en = 0; negs(1);
    chk(cfg_err == 1'b0, "R10 cfg_err clear", real'(cfg_err), 0.0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule